// File: doc/BRIEF.md
# GF(2^128) Montgomery Field Multiplier

This block multiplies two 128-bit elements of the binary field used by the POLYVAL universal hash. It returns a·b·x^-128 reduced modulo P(x) = x^128 + x^127 + x^126 + x^121 + 1. Operands that are already in Montgomery form therefore give a product that is also in Montgomery form. All arithmetic is carry-less, so addition is XOR. In every 128-bit vector, bit i holds the coefficient of x^i. A 16-byte block in little-endian byte order maps onto the port with byte 0 in bits 7:0.

The datapath is iterative and has a single 64x64 carry-less multiplier. Four cycles build the 256-bit product from the four lane products: low·low, low·high, high·low and high·high. Two more cycles perform the Montgomery fold with the 64-bit constant 0xC200000000000000. Software or a hash engine offers operands with a valid/ready handshake. The result comes back with a one-cycle valid pulse and then stays on the result port until the next result replaces it.

Top module: `pv_montmul`

## Requirements
- R1: While reset is held and after it is released, `res_valid` is 0, `req_ready` is 1 and `res_data` is all zeros, until the first operation completes.
- R2: For any operands a and b, `res_data` equals a·b·x^-128 mod (x^128+x^127+x^126+x^121+1). The arithmetic is carry-less, and bit i of each 128-bit vector is the coefficient of x^i.
- R3: Multiplying any a by the Montgomery one, R = x^128 mod P = 0xC2000000_00000000_00000000_00000001 (bits 127, 126, 121 and 0 set), returns a unchanged.
- R4: If either operand is all zeros, the result is all zeros.
- R5: `res_valid` is high for exactly one cycle. It rises on the sixth rising clock edge after the edge that accepts the request (`req_valid` and `req_ready` both high).
- R6: `req_ready` is low from the accepting edge until the result is produced. A `req_valid` raised in that window is ignored: it does not alter the result in progress and does not cause an extra result pulse.
- R7: `res_data` holds its value in every cycle in which `res_valid` is low.
- R8: `req_ready` is high in the cycle in which `res_valid` is high, so a new operation can be accepted on the edge that ends the result pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Operand pair offered |
| req_ready | output | 1 | Block idle and able to accept operands |
| op_a | input | 128 | First operand, bit i = coefficient of x^i |
| op_b | input | 128 | Second operand, bit i = coefficient of x^i |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 128 | a·b·x^-128 mod P, held between pulses |

## Verification
Every pair of single-term operands x^i · x^j over all 128 × 128 positions is multiplied. This sweep separates each lane product and each shift of the middle term, and it exercises every fold path on its own, so a misplaced half or a wrong constant bit shows up at a specific (i, j). Random dense operands and all-ones operands then test how the four lane products and the two folds combine. The zero operands and the Montgomery one check the degenerate and identity results. The timing-specific requirements get their own tests: a request poked while the block is busy, a chained request issued during the result pulse, and a hold window after each result.

// File: rtl/pv_pkg.sv
// Package pv_pkg
// Shared step encoding for the iterative Montgomery multiplier. The order
// of the steps is the schedule: four lane products, then two folds.
package pv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LL   = 3'd1,
        ST_LH   = 3'd2,
        ST_HL   = 3'd3,
        ST_HH   = 3'd4,
        ST_F1   = 3'd5,
        ST_F2   = 3'd6
    } step_t;
endpackage

// File: rtl/pv_clmul.sv
// Module pv_clmul
// Combinational carry-less multiplier of two W-bit polynomials. The result
// is 2W bits wide, and its top bit is always zero.
// Assumes: bit i of each operand is the coefficient of x^i.
module pv_clmul #(
    parameter int W = 64
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] z
);
    localparam int ZW = 2 * W;

    logic [ZW-1:0] row [W];

    // One shifted copy of x for each set bit of y
    generate
        for (genvar i = 0; i < W; i++) begin : g_row
            assign row[i] = y[i] ? ({{W{1'b0}}, x} << i) : '0;
        end
    endgenerate

    // XOR tree over all rows
    always_comb begin
        z = '0;
        for (int i = 0; i < W; i++) begin
            z = z ^ row[i];
        end
    end
endmodule

// File: rtl/pv_opsel.sv
// Module pv_opsel
// Picks the operands of the shared lane multiplier for the current step.
// The product steps use the captured operand halves. The fold steps use the
// low or the high half of the running low word against the fold constant.
// Assumes: step is ST_IDLE whenever no operation is running.
module pv_opsel
    import pv_pkg::*;
#(
    parameter int               LW     = 64,
    parameter logic [LW-1:0]    FOLD_K = 64'hC200_0000_0000_0000
) (
    input  step_t             step,
    input  logic [2*LW-1:0]   opa,
    input  logic [2*LW-1:0]   opb,
    input  logic [2*LW-1:0]   acc_lo,
    output logic [LW-1:0]     mx,
    output logic [LW-1:0]     my
);
    // Operand routing by step
    always_comb begin
        mx = '0;
        my = '0;
        case (step)
            ST_LL: begin mx = opa[LW-1:0];       my = opb[LW-1:0];       end
            ST_LH: begin mx = opa[LW-1:0];       my = opb[2*LW-1:LW];    end
            ST_HL: begin mx = opa[2*LW-1:LW];    my = opb[LW-1:0];       end
            ST_HH: begin mx = opa[2*LW-1:LW];    my = opb[2*LW-1:LW];    end
            ST_F1: begin mx = acc_lo[LW-1:0];    my = FOLD_K;            end
            ST_F2: begin mx = acc_lo[2*LW-1:LW]; my = FOLD_K;            end
            default: begin mx = '0;              my = '0;                end
        endcase
    end
endmodule

// File: rtl/pv_accum.sv
// Module pv_accum
// Holds the 256-bit product as two 128-bit words, lo_q and hi_q, and
// applies one step per cycle:
//   LL: lo ^= p
//   LH, HL: lo ^= p_low << LW; hi ^= p_high
//   HH: hi ^= p
//   F1: lo ^= half-swapped p; then hi ^= lo
//   F2: hi ^= p
// After F2, hi holds the reduced result. hi_nxt shows that value one cycle
// early so that the top can register it.
// Assumes: clear is asserted on the edge that accepts a new operation.
module pv_accum
    import pv_pkg::*;
#(
    parameter int LW = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  step_t           step,
    input  logic [2*LW-1:0] prod,
    output logic [2*LW-1:0] lo_q,
    output logic [2*LW-1:0] hi_q,
    output logic [2*LW-1:0] hi_nxt
);
    localparam int BW = 2 * LW;

    logic [BW-1:0] lo_nxt;

    // Next-state update of both words for the current step
    always_comb begin
        lo_nxt = lo_q;
        hi_nxt = hi_q;
        case (step)
            ST_LL: lo_nxt = lo_q ^ prod;
            ST_LH, ST_HL: begin
                lo_nxt = lo_q ^ {prod[LW-1:0], {LW{1'b0}}};
                hi_nxt = hi_q ^ {{LW{1'b0}}, prod[BW-1:LW]};
            end
            ST_HH: hi_nxt = hi_q ^ prod;
            ST_F1: begin
                lo_nxt = lo_q ^ {prod[LW-1:0], prod[BW-1:LW]};
                hi_nxt = hi_q ^ lo_nxt;
            end
            ST_F2: hi_nxt = hi_q ^ prod;
            default: begin
                lo_nxt = lo_q;
                hi_nxt = hi_q;
            end
        endcase
    end

    // Word registers, cleared on reset and on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_nxt;
            hi_q <= hi_nxt;
        end
    end
endmodule

// File: rtl/pv_montmul.sv
// Module pv_montmul
// Iterative Montgomery multiplier over GF(2^128) with the POLYVAL modulus.
// It computes a*b*x^-128 mod (x^128+x^127+x^126+x^121+1). A single 64x64
// carry-less multiplier is stepped through four lane products and two
// reduction folds. The result valid pulses six edges after acceptance,
// and the result is held until the next one.
// Assumes: BLK_W is 128 for the modulus that FOLD_K encodes.
module pv_montmul
    import pv_pkg::*;
#(
    parameter int                 BLK_W  = 128,
    parameter logic [BLK_W/2-1:0] FOLD_K = 64'hC200_0000_0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BLK_W-1:0] op_a,
    input  logic [BLK_W-1:0] op_b,
    output logic             res_valid,
    output logic [BLK_W-1:0] res_data
);
    localparam int LW      = BLK_W / 2;
    localparam int LANES   = BLK_W / LW;
    localparam int N_PART  = LANES * LANES;
    localparam int N_FOLD  = 2;
    localparam int LAT     = N_PART + N_FOLD;
    localparam int CNT_W   = $clog2(LAT + 3);

    step_t            step_q;
    logic [BLK_W-1:0] opa_q, opb_q;
    logic [BLK_W-1:0] acc_lo, acc_hi, acc_hi_nxt;
    logic [LW-1:0]    mx, my;
    logic [BLK_W-1:0] prod;
    logic             accept;

    assign req_ready = (step_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Step sequencer: idle, four products, two folds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= ST_IDLE;
        end else begin
            case (step_q)
                ST_IDLE: if (accept) step_q <= ST_LL;
                ST_LL:   step_q <= ST_LH;
                ST_LH:   step_q <= ST_HL;
                ST_HL:   step_q <= ST_HH;
                ST_HH:   step_q <= ST_F1;
                ST_F1:   step_q <= ST_F2;
                default: step_q <= ST_IDLE;
            endcase
        end
    end

    // Operand capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if (accept) begin
            opa_q <= op_a;
            opb_q <= op_b;
        end
    end

    pv_opsel #(.LW(LW), .FOLD_K(FOLD_K)) u_opsel (
        .step   (step_q),
        .opa    (opa_q),
        .opb    (opb_q),
        .acc_lo (acc_lo),
        .mx     (mx),
        .my     (my)
    );

    pv_clmul #(.W(LW)) u_mul (
        .x (mx),
        .y (my),
        .z (prod)
    );

    pv_accum #(.LW(LW)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .step   (step_q),
        .prod   (prod),
        .lo_q   (acc_lo),
        .hi_q   (acc_hi),
        .hi_nxt (acc_hi_nxt)
    );

    // Result register and one-cycle valid pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= (step_q == ST_F2);
            if (step_q == ST_F2) res_data <= acc_hi_nxt;
        end
    end

    // Checker state: cycles since acceptance, and whether an operand was zero
    logic [CNT_W-1:0] lat_cnt;
    logic             zero_op_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt   <= '0;
            zero_op_q <= 1'b0;
        end else if (accept) begin
            lat_cnt   <= 1;
            zero_op_q <= (op_a == '0) || (op_b == '0);
        end else if (lat_cnt != '0 && lat_cnt < CNT_W'(LAT + 2)) begin
            lat_cnt   <= lat_cnt + 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R5
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (lat_cnt == CNT_W'(LAT + 1))); // R5
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R6
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_data)); // R7
    AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> req_ready); // R8
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && zero_op_q) |-> (res_data == '0)); // R4
endmodule

// File: tb/pv_montmul_test.sv
module pv_montmul_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [127:0] op_a = '0;
    logic [127:0] op_b = '0;
    logic         res_valid;
    logic [127:0] res_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    localparam logic [127:0] MONT_ONE = {8'hC2, 56'h0, 63'h0, 1'b1};

    always #2.5 clk = ~clk;

    pv_montmul uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_data(res_data)
    );

    // Bit-serial model: full product, then 128 divide-by-x steps mod P
    function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
        logic [255:0] p = '0;
        logic [255:0] poly = '0;
        poly[128] = 1'b1; poly[127] = 1'b1; poly[126] = 1'b1; poly[121] = 1'b1; poly[0] = 1'b1;
        for (int i = 0; i < 128; i++)
            if (b[i]) p = p ^ ({128'h0, a} << i);
        for (int k = 0; k < 128; k++) begin
            if (p[0]) p = p ^ poly;
            p = p >> 1;
        end
        return p[127:0];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // One operation; poke=1 raises req_valid again while busy (R6)
    task automatic run_op(input logic [127:0] a, input logic [127:0] b, input string req, input bit poke);
        int seen = 0;
        logic [127:0] exp = ref_mul(a, b);
        while (!req_ready) @(negedge clk);
        op_a = a; op_b = b; req_valid = 1'b1;
        for (int n = 1; n <= 7; n++) begin
            @(negedge clk);
            if (n == 1) req_valid = 1'b0;
            if (poke && n == 3) begin
                op_a = rnd128(); op_b = rnd128(); req_valid = 1'b1;
            end
            if (poke && n == 4) begin
                chk(req_ready == 1'b0, "R6 ready low while busy", {127'h0, req_ready}, 128'h0);
                req_valid = 1'b0;
            end
            if (res_valid && seen == 0) seen = n;
        end
        chk(seen == 7, "R5 latency", 128'(seen), 128'd7);
        chk(res_data == exp, req, res_data, exp);
        if (poke) begin
            @(negedge clk);
            chk(res_valid == 1'b0, "R6 no extra result", {127'h0, res_valid}, 128'h0);
            chk(res_data == exp, "R6 result unaffected", res_data, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<195000", cycles);
            summary();
        end
    end

    initial begin
        logic [127:0] a, b, hold;
        repeat (4) @(negedge clk);
        // R1: state during and after reset
        chk(res_valid == 1'b0 && req_ready == 1'b1 && res_data == '0, "R1 reset state", res_data, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0 && req_ready == 1'b1 && res_data == '0, "R1 after release", res_data, 128'h0);

        // R4: zero operands
        run_op(128'h0, rnd128(), "R4 zero a", 1'b0);
        run_op(rnd128(), 128'h0, "R4 zero b", 1'b0);
        run_op(128'h0, 128'h0, "R4 both zero", 1'b0);

        // R3: Montgomery one is the identity
        for (int k = 0; k < 8; k++) begin
            a = rnd128();
            run_op(a, MONT_ONE, "R3 identity", 1'b0);
            chk(res_data == a, "R3 returns a", res_data, a);
        end
        run_op(MONT_ONE, MONT_ONE, "R3 one squared", 1'b0);
        chk(res_data == MONT_ONE, "R3 one squared value", res_data, MONT_ONE);

        // R2: exhaustive single-term sweep x^i * x^j
        for (int i = 0; i < 128; i++)
            for (int j = 0; j < 128; j++)
                run_op(128'h1 << i, 128'h1 << j, "R2 single term", 1'b0);

        // R2: dense, all-ones and lane-isolated operands
        run_op({128{1'b1}}, {128{1'b1}}, "R2 all ones", 1'b0);
        run_op({64'h0, {64{1'b1}}}, {{64{1'b1}}, 64'h0}, "R2 lo by hi", 1'b0);
        for (int k = 0; k < 200; k++)
            run_op(rnd128(), rnd128(), "R2 random", 1'b0);

        // R6: request while busy is ignored
        for (int k = 0; k < 4; k++)
            run_op(rnd128(), rnd128(), "R6 busy op result", 1'b1);

        // R7: result held after the pulse
        run_op(rnd128(), rnd128(), "R7 setup", 1'b0);
        hold = res_data;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(res_valid == 1'b0 && res_data == hold, "R7 result held", res_data, hold);
        end

        // R8: chain a request during the result pulse
        a = rnd128(); b = rnd128();
        run_op(rnd128(), rnd128(), "R8 first", 1'b0);
        chk(req_ready == 1'b1 && res_valid == 1'b1, "R8 ready during pulse", {127'h0, req_ready}, 128'h1);
        run_op(a, b, "R8 chained result", 1'b0);

        summary();
    end
endmodule